// File: doc/BRIEF.md
# Square-root carry-select adder

This block adds two 20-bit unsigned operands and a carry-in. The result is a 20-bit sum and a carry-out. It is purely combinational and sits in a datapath wherever a wide add must settle faster than a single ripple chain allows. There are no registers, so the result follows the inputs within the same cycle.

The operand is split into five groups. Their widths grow by one bit from the least significant end: bits 1..0, 4..2, 8..5, 13..9 and 19..14. The lowest group is an ordinary ripple adder fed by the external carry-in. Each higher group does the following:

- It forms per-bit propagate and generate terms.
- It runs two carry chains side by side, one assuming an incoming carry of 0 and one assuming 1.
- When the true carry from the group below arrives, a multiplexer picks both the group's sum bits and its carry-out.

The selected carry-out of each group then drives the select of the next group. Because each group is one bit wider than the one below it, its local chain takes one step longer, which matches the one extra multiplexer step its select carry needs to arrive.

Top module: `sqrt_csel_adder`

## Requirements
- R1: `{cout, sum_out}` equals `a_in + b_in + cin` as an unsigned 21-bit value for every combination of inputs.
- R2: `sum_out[1:0]` depends only on `a_in[1:0]`, `b_in[1:0]` and `cin`. Changing any operand bit above bit 1 leaves it unchanged.
- R3: The group boundaries lie at bits 2, 5, 9 and 14, giving group widths 2, 3, 4, 5 and 6. A carry generated below a boundary is delivered into the bit just above it, for example `(2**n - 1) + 1 = 2**n` for n in {2, 5, 9, 14}.
- R4: A group whose bits all propagate (`a_in ^ b_in` all ones within the group) passes its incoming carry unchanged to the next group.
- R5: `cout` is the selected carry-out of the top group (bits 19..14). All ones plus one yields `sum_out = 0` and `cout = 1`.
- R6: For fixed operands, the 21-bit result with `cin = 1` is exactly one more than the result with `cin = 0`, modulo 2**21.
- R7: A group that receives no carry from below produces the low bits of the sum of its own operand slices.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 20 | First operand |
| b_in | input | 20 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum_out | output | 20 | Sum bits |
| cout | output | 1 | Carry out of bit 19 |

## Verification
The checker's immediate assertions assume the inputs are settled, two-valued levels whenever the combinational logic is evaluated. For that reason each check is skipped while any input is unknown. The bench keeps within this assumption in two ways:

- It drives every input from a known value from time zero.
- It changes the inputs only on the falling clock edge, and samples one nanosecond later, after the logic has settled.

Beyond random operands, the stimulus deliberately sets up three patterns in every group: a generated carry, a fully propagating run, and no incoming carry.

// File: rtl/sqrt_csel_adder.sv
module sqrt_csel_adder #(
  parameter int BASE_W = 2,
  parameter int GROUPS = 5,
  localparam int DATA_W = GROUPS * BASE_W + (GROUPS * (GROUPS - 1)) / 2
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              cin,
  output logic [DATA_W-1:0] sum_out,
  output logic              cout
);

  function automatic int grp_lo(input int k);
    return k * BASE_W + (k * (k - 1)) / 2;
  endfunction

  logic [DATA_W-1:0] prop;
  logic [DATA_W-1:0] gen;
  logic [GROUPS:0]   csel;
  logic [GROUPS-1:0] co0;
  logic [GROUPS-1:0] co1;

  assign prop    = a_in ^ b_in;
  assign gen     = a_in & b_in;
  assign csel[0] = cin;

  for (genvar k = 0; k < GROUPS; k++) begin : g_grp
    localparam int LO = grp_lo(k);
    localparam int W  = BASE_W + k;
    logic [W:0] c0;
    logic [W:0] c1;

    if (k == 0) begin : g_ripple
      always_comb begin
        c0[0] = csel[0];
        for (int i = 0; i < W; i++)
          c0[i+1] = gen[LO+i] | (prop[LO+i] & c0[i]);
      end
      assign c1             = c0;
      assign sum_out[LO+:W] = prop[LO+:W] ^ c0[W-1:0];
      assign csel[k+1]      = c0[W];
    end else begin : g_select
      always_comb begin
        c0[0] = 1'b0;
        c1[0] = 1'b1;
        for (int i = 0; i < W; i++) begin
          c0[i+1] = gen[LO+i] | (prop[LO+i] & c0[i]);
          c1[i+1] = gen[LO+i] | (prop[LO+i] & c1[i]);
        end
      end
      assign sum_out[LO+:W] = csel[k] ? (prop[LO+:W] ^ c1[W-1:0])
                                      : (prop[LO+:W] ^ c0[W-1:0]);
      assign csel[k+1]      = csel[k] ? c1[W] : c0[W];
    end

    assign co0[k] = c0[W];
    assign co1[k] = c1[W];
  end

  assign cout = csel[GROUPS];

endmodule

// File: rtl/sqrt_csel_adder_chk.sv
module sqrt_csel_adder_chk #(
  parameter int BASE_W = 2,
  parameter int GROUPS = 5,
  parameter int DATA_W = 20
) (
  input logic [DATA_W-1:0] a_in,
  input logic [DATA_W-1:0] b_in,
  input logic              cin,
  input logic [DATA_W-1:0] sum_out,
  input logic              cout,
  input logic [GROUPS:0]   grp_carry,
  input logic [GROUPS-1:0] grp_co0,
  input logic [GROUPS-1:0] grp_co1
);

  function automatic int lo_of(input int k);
    return k * BASE_W + (k * (k - 1)) / 2;
  endfunction

  always_comb begin
    if (!$isunknown({a_in, b_in, cin})) begin
      AST_SUM_EXACT: assert ({cout, sum_out} == ({1'b0, a_in} + {1'b0, b_in} + {{DATA_W{1'b0}}, cin})) // R1
        else $error("sum mismatch");
      AST_COUT_TOP: assert (cout == grp_carry[GROUPS]) // R5
        else $error("carry-out not from top group");
      for (int k = 0; k < GROUPS; k++) begin
        automatic int hi = lo_of(k + 1);
        automatic logic [DATA_W:0] msk = ({{DATA_W{1'b0}}, 1'b1} << hi) - 1'b1;
        automatic logic [DATA_W:0] t = ({1'b0, a_in} & msk) + ({1'b0, b_in} & msk)
                                       + {{DATA_W{1'b0}}, cin};
        automatic logic [DATA_W-1:0] gm = msk[DATA_W-1:0]
                                          & ~((({DATA_W{1'b0}} | 1'b1) << lo_of(k)) - 1'b1);
        AST_GROUP_CARRY: assert (grp_carry[k+1] == t[hi]) // R3
          else $error("carry out of group %0d wrong", k);
        AST_CHAIN_ORDER: assert (!grp_co0[k] || grp_co1[k]) // R7
          else $error("zero-carry chain exceeds one-carry chain in group %0d", k);
        AST_PROP_PASS: assert (((a_in ^ b_in) & gm) != gm || grp_carry[k+1] == grp_carry[k]) // R4
          else $error("propagating group %0d did not pass carry", k);
      end
    end
  end

endmodule

bind sqrt_csel_adder sqrt_csel_adder_chk #(
  .BASE_W(BASE_W), .GROUPS(GROUPS), .DATA_W(DATA_W)
) u_chk (
  .a_in(a_in), .b_in(b_in), .cin(cin), .sum_out(sum_out), .cout(cout),
  .grp_carry(csel), .grp_co0(co0), .grp_co1(co1)
);

// File: tb/test_sqrt_csel_adder.sv
`timescale 1ns/1ps
module test_sqrt_csel_adder;
  localparam int W = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         ci = 1'b0;
  logic [W-1:0] s;
  logic         co;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // {cin, a, b}
  localparam logic [40:0] VECS [12] = '{
    {1'b0, 20'h00000, 20'h00000},
    {1'b1, 20'h00000, 20'h00000},
    {1'b0, 20'hFFFFF, 20'h00001},
    {1'b1, 20'hFFFFF, 20'h00000},
    {1'b1, 20'hFFFFF, 20'hFFFFF},
    {1'b0, 20'h12345, 20'h6789A},
    {1'b0, 20'hAAAAA, 20'h55555},
    {1'b1, 20'hAAAAA, 20'h55555},
    {1'b0, 20'h80000, 20'h80000},
    {1'b0, 20'h0F0F0, 20'h0F0F0},
    {1'b1, 20'h3C3C3, 20'hC3C3C},
    {1'b0, 20'h7FFFF, 20'h00001}
  };
  localparam int BND [6] = '{0, 2, 5, 9, 14, 20};

  sqrt_csel_adder i_sqrt_csel_adder (
    .a_in(a), .b_in(b), .cin(ci), .sum_out(s), .cout(co)
  );

  always #2 clk = ~clk;

  function automatic logic [W:0] ref_add(logic [W-1:0] x, logic [W-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  task automatic check(string req, logic [W:0] got, logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] x, logic [W-1:0] y, logic c);
    @(negedge clk);
    a = x; b = y; ci = c;
    #1;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W:0] r0;
    logic [W-1:0] m;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", {co, s}, '0);
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      apply(VECS[i][39:20], VECS[i][19:0], VECS[i][40]);
      check("R1 table", {co, s}, ref_add(VECS[i][39:20], VECS[i][19:0], VECS[i][40]));
    end

    apply('1, 20'h1, 1'b0);
    check("R5 all ones plus one", {co, s}, {1'b1, 20'h0});

    for (int k = 1; k < 5; k++) begin
      m = 20'((21'(1) << BND[k]) - 1);
      apply(m, 20'h1, 1'b0);
      check("R3 boundary via b", {co, s}, 21'(1) << BND[k]);
      apply(m, 20'h0, 1'b1);
      check("R3 boundary via cin", {co, s}, 21'(1) << BND[k]);
    end

    for (int k = 0; k < 5; k++) begin
      m = 20'((21'(1) << BND[k+1]) - 1);
      apply(m & 20'h5A5A5, m & ~20'h5A5A5, 1'b1);
      check("R4 full propagate", {co, s}, 21'(1) << BND[k+1]);
      apply(m & 20'h5A5A5, m & ~20'h5A5A5, 1'b0);
      check("R4 propagate no carry", {co, s}, {1'b0, m});
    end

    for (int k = 1; k < 5; k++) begin
      m = 20'((21'(1) << BND[k+1]) - (21'(1) << BND[k]));
      for (int j = 0; j < 8; j++) begin
        logic [W-1:0] x, y;
        x = $urandom() & m;
        y = $urandom() & m;
        apply(x, y, 1'b0);
        check("R7 isolated group", {co, s}, ref_add(x, y, 1'b0));
      end
    end

    for (int j = 0; j < 40; j++) begin
      logic [W-1:0] x, y, u;
      logic [1:0] lo;
      x = $urandom(); y = $urandom(); u = $urandom() | 20'h4;
      apply(x, y, j[0]);
      lo = s[1:0];
      check("R2 low group value", {19'b0, lo}, 21'((x[1:0] + y[1:0] + 2'(j[0])) & 2'h3));
      apply(x ^ (u & ~20'h3), y, j[0]);
      check("R2 low group isolated", {19'b0, s[1:0]}, {19'b0, lo});
    end

    for (int j = 0; j < 100; j++) begin
      logic [W-1:0] x, y;
      x = $urandom(); y = $urandom();
      apply(x, y, 1'b0);
      r0 = {co, s};
      apply(x, y, 1'b1);
      check("R6 carry-in step", {co, s}, r0 + 21'd1);
    end

    for (int j = 0; j < 3000; j++) begin
      logic [W-1:0] x, y;
      logic c;
      x = $urandom(); y = $urandom(); c = 1'($urandom());
      apply(x, y, c);
      check("R1 random", {co, s}, ref_add(x, y, c));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule